// File: doc/BRIEF.md
# SONET Frame Defect Monitor

This block watches the framing health of a received STS-3 stream and turns it into three defect flags: loss of signal, severely errored framing and loss of frame. An upstream frame aligner gives it one strobe per frame period, together with a flag that says whether the frame's alignment bytes matched. A level input carries the loss-of-signal condition. The block does no byte search and no parity work of its own.

Framing is followed through four states, coded by the pair (SEF, LOF): in frame, SEF only, SEF with LOF, and LOF only. Once the block reaches LOF only, it counts consecutive clean frames against a threshold that software can program, and it declares the stream in frame when the count is reached. Every change of a defect flag can latch a pending bit in an interrupt register, which clears when it is read. Each pending bit has its own enable, and any enabled pending bit pulls an active-low interrupt line low.

Software sees four 8-bit registers on a small read/write port. Address 0 holds the defect flags (read only). Address 1 holds the pending interrupt bits, cleared on read. Address 2 holds the interrupt enables. Address 3 holds the in-sync threshold. Reads are combinational. Writes and read side effects take place at the clock edge.

Top module: `sonet_frame_defect_mon`

## Requirements
- R1: After reset the defect register reads 0x07, the pending, enable and threshold registers read 0x00, 0x00 and THR_INIT (default 8), and irq_n is high.
- R2: Address 0 shows LOS in bit 0, SEF in bit 1 and LOF in bit 2, with the upper bits reading 0. Writes to address 0 or address 1 change nothing.
- R3: In frame, SEF_BAD_FRAMES (default 4) consecutive frame strobes with frm_ok low declare SEF. A good frame restarts the run. frm_ok is ignored in cycles without frm_tick.
- R4: With SEF declared, SEF_GOOD_FRAMES (default 2) consecutive good frames clear SEF. From SEF only, this returns the block to in frame.
- R5: If SEF stays declared for LOF_PERSIST_FRAMES (default 8) frame strobes, LOF is declared as well. LOF is never declared while SEF is clear.
- R6: With SEF clear and LOF declared, LOF clears after N consecutive good frames, where N is the threshold register bits 3:0 and a value of 0 counts as 1. A bad frame restarts the count.
- R7: With SEF clear and LOF declared, SEF_BAD_FRAMES consecutive bad frames declare SEF again while LOF stays declared.
- R8: The LOS flag takes the value of los_in one clock later.
- R9: A change in defect bit i sets pending bit i (same bit positions as R2) at the same edge, but only if enable bit i was set before that edge.
- R10: A read of address 1 returns the pending bits and clears them at that edge. A change event in the same cycle wins, and its bit stays set.
- R11: irq_n is low exactly when some pending bit is set and its enable bit is set.
- R12: The enable register keeps bits 2:0 and the threshold register keeps bits 3:0 of a write to address 2 or 3. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_tick | input | 1 | One-cycle strobe per received frame |
| frm_ok | input | 1 | Alignment bytes of this frame matched; valid with frm_tick |
| los_in | input | 1 | Loss-of-signal level from the line side |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect for address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
On every cycle the assertions check the following rules. SEF rises only on a bad frame. LOF rises only when SEF is already declared. LOF falls only on a good frame with SEF clear. LOS trails los_in by one cycle. A change in SEF with its enable set latches a pending bit. A read of address 1 with no change of defect leaves nothing pending. A low irq_n implies a set enable and a set pending bit. The exact frame counts before each transition can only be shown by the bench scenarios, which a cycle model checks on every clock. The same holds for the threshold of 0 counted as 1, the restart of the clean-frame count after a bad frame, the return from LOF only to SEF, the event that wins over a read in the same cycle, and the masking of write data.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

  // Bit 0 of the state is the SEF flag, bit 1 the LOF flag.
  typedef enum logic [1:0] {
    FS_INFRAME = 2'b00,
    FS_SEF     = 2'b01,
    FS_SEF_LOF = 2'b11,
    FS_LOF     = 2'b10
  } frm_state_e;

  localparam int NUM_DEF = 3;
  localparam int DEF_LOS = 0;
  localparam int DEF_SEF = 1;
  localparam int DEF_LOF = 2;

  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_STAT = 2'd0;
  localparam logic [REG_AW-1:0] A_ISR  = 2'd1;
  localparam logic [REG_AW-1:0] A_IEN  = 2'd2;
  localparam logic [REG_AW-1:0] A_THR  = 2'd3;

endpackage

// File: rtl/fdm_rst_sync.sv
module fdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  assign sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/fdm_frame_fsm.sv
module fdm_frame_fsm
  import fdm_pkg::*;
#(
  parameter int SEF_BAD_FRAMES     = 4,
  parameter int SEF_GOOD_FRAMES    = 2,
  parameter int LOF_PERSIST_FRAMES = 8,
  parameter int THR_W              = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_tick,
  input  logic             frm_ok,
  input  logic [THR_W-1:0] thr,
  output logic             sef_o,
  output logic             lof_o,
  output logic             sef_ev,
  output logic             lof_ev
);

  localparam int MAX_A   = (SEF_BAD_FRAMES > SEF_GOOD_FRAMES) ? SEF_BAD_FRAMES : SEF_GOOD_FRAMES;
  localparam int THR_MAX = (2 ** THR_W) - 1;
  localparam int MAX_RUN = (MAX_A > THR_MAX) ? MAX_A : THR_MAX;
  localparam int RUN_W   = $clog2(MAX_RUN + 1);
  localparam int PER_W   = $clog2(LOF_PERSIST_FRAMES + 1);

  localparam logic [RUN_W-1:0] RUN_SAT  = {RUN_W{1'b1}};
  localparam logic [PER_W-1:0] PER_SAT  = {PER_W{1'b1}};
  localparam logic [RUN_W-1:0] BAD_LIM  = RUN_W'(SEF_BAD_FRAMES);
  localparam logic [RUN_W-1:0] GOOD_LIM = RUN_W'(SEF_GOOD_FRAMES);
  localparam logic [PER_W-1:0] PER_LIM  = PER_W'(LOF_PERSIST_FRAMES);

  frm_state_e       st_q, st_d;
  logic [RUN_W-1:0] good_q, good_d, good_inc;
  logic [RUN_W-1:0] bad_q, bad_d, bad_inc;
  logic [PER_W-1:0] per_q, per_d, per_inc;
  logic [RUN_W-1:0] need;

  // saturating increments
  assign good_inc = (good_q == RUN_SAT) ? good_q : good_q + 1'b1;
  assign bad_inc  = (bad_q  == RUN_SAT) ? bad_q  : bad_q  + 1'b1;
  assign per_inc  = (per_q  == PER_SAT) ? per_q  : per_q  + 1'b1;

  // in-sync frame count, zero treated as one
  assign need = (thr == '0) ? RUN_W'(1) : RUN_W'(thr);

  // next-state process
  always_comb begin
    st_d   = st_q;
    good_d = good_q;
    bad_d  = bad_q;
    per_d  = per_q;
    if (frm_tick) begin
      good_d = frm_ok ? good_inc : '0;
      bad_d  = frm_ok ? '0 : bad_inc;
      per_d  = (st_q == FS_SEF) ? per_inc : '0;
      unique case (st_q)
        FS_INFRAME: begin
          if (!frm_ok && bad_inc >= BAD_LIM) st_d = FS_SEF;
        end
        FS_SEF: begin
          if (frm_ok && good_inc >= GOOD_LIM) st_d = FS_INFRAME;
          else if (per_inc >= PER_LIM)        st_d = FS_SEF_LOF;
        end
        FS_SEF_LOF: begin
          if (frm_ok && good_inc >= GOOD_LIM) st_d = FS_LOF;
        end
        FS_LOF: begin
          if (frm_ok && good_inc >= need)         st_d = FS_INFRAME;
          else if (!frm_ok && bad_inc >= BAD_LIM) st_d = FS_SEF_LOF;
        end
        default: st_d = FS_SEF_LOF;
      endcase
      if (st_d != st_q) begin
        good_d = '0;
        bad_d  = '0;
        per_d  = '0;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_SEF_LOF;
      good_q <= '0;
      bad_q  <= '0;
      per_q  <= '0;
    end else if (frm_tick) begin
      st_q   <= st_d;
      good_q <= good_d;
      bad_q  <= bad_d;
      per_q  <= per_d;
    end
  end

  assign sef_o  = st_q[0];
  assign lof_o  = st_q[1];
  assign sef_ev = st_d[0] ^ st_q[0];
  assign lof_ev = st_d[1] ^ st_q[1];

endmodule

// File: rtl/fdm_los_track.sv
module fdm_los_track (
  input  logic clk,
  input  logic rst_n,
  input  logic los_in,
  output logic los_o,
  output logic los_ev
);

  logic los_q;
  logic los_d;

  assign los_d = los_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) los_q <= 1'b1;
    else        los_q <= los_d;
  end

  assign los_o  = los_q;
  assign los_ev = los_d ^ los_q;

endmodule

// File: rtl/fdm_reg_if.sv
module fdm_reg_if
  import fdm_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               THR_W    = 4,
  parameter logic [THR_W-1:0] THR_INIT = 4'd8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_DEF-1:0] defects,
  input  logic [NUM_DEF-1:0] events,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_n,
  output logic [THR_W-1:0]   thr_o,
  output logic [NUM_DEF-1:0] ist_o,
  output logic [NUM_DEF-1:0] ien_o
);

  logic [NUM_DEF-1:0] ist_q, ist_d;
  logic [NUM_DEF-1:0] ien_q, ien_d;
  logic [THR_W-1:0]   thr_q, thr_d;
  logic               wr_ien, wr_thr, rd_isr;
  logic               unused_wbits;

  assign wr_ien       = reg_wr && (reg_addr == A_IEN);
  assign wr_thr       = reg_wr && (reg_addr == A_THR);
  assign rd_isr       = reg_rd && (reg_addr == A_ISR);
  assign unused_wbits = ^reg_wdata[DATA_W-1:THR_W];

  always_comb begin
    ien_d = ien_q;
    thr_d = thr_q;
    if (wr_ien) ien_d = reg_wdata[NUM_DEF-1:0];
    if (wr_thr) thr_d = reg_wdata[THR_W-1:0];
  end

  // one pending bit per defect: a new event wins over a clear by read
  for (genvar i = 0; i < NUM_DEF; i++) begin : g_pend
    assign ist_d[i] = (events[i] & ien_q[i]) | (ist_q[i] & ~rd_isr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q <= '0;
      ien_q <= '0;
      thr_q <= THR_INIT;
    end else begin
      ist_q <= ist_d;
      ien_q <= ien_d;
      thr_q <= thr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_STAT:  reg_rdata[NUM_DEF-1:0] = defects;
      A_ISR:   reg_rdata[NUM_DEF-1:0] = ist_q;
      A_IEN:   reg_rdata[NUM_DEF-1:0] = ien_q;
      A_THR:   reg_rdata[THR_W-1:0]   = thr_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_n = ~|(ist_q & ien_q);
  assign thr_o = thr_q;
  assign ist_o = ist_q;
  assign ien_o = ien_q;

endmodule

// File: rtl/sonet_frame_defect_mon.sv
module sonet_frame_defect_mon
  import fdm_pkg::*;
#(
  parameter int               SEF_BAD_FRAMES     = 4,
  parameter int               SEF_GOOD_FRAMES    = 2,
  parameter int               LOF_PERSIST_FRAMES = 8,
  parameter int               THR_W              = 4,
  parameter logic [THR_W-1:0] THR_INIT           = 4'd8,
  parameter int               DATA_W             = 8,
  parameter int               RST_STAGES         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_tick,
  input  logic              frm_ok,
  input  logic              los_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);

  logic               rst_sync_n;
  logic               sef, lof, los;
  logic               sef_ev, lof_ev, los_ev;
  logic [THR_W-1:0]   thr;
  logic [NUM_DEF-1:0] defect_vec, event_vec;
  logic [NUM_DEF-1:0] int_stat, int_en;

  fdm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  fdm_frame_fsm #(
    .SEF_BAD_FRAMES     (SEF_BAD_FRAMES),
    .SEF_GOOD_FRAMES    (SEF_GOOD_FRAMES),
    .LOF_PERSIST_FRAMES (LOF_PERSIST_FRAMES),
    .THR_W              (THR_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .frm_tick (frm_tick),
    .frm_ok   (frm_ok),
    .thr      (thr),
    .sef_o    (sef),
    .lof_o    (lof),
    .sef_ev   (sef_ev),
    .lof_ev   (lof_ev)
  );

  fdm_los_track u_los (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .los_in (los_in),
    .los_o  (los),
    .los_ev (los_ev)
  );

  always_comb begin
    defect_vec          = '0;
    event_vec           = '0;
    defect_vec[DEF_LOS] = los;
    defect_vec[DEF_SEF] = sef;
    defect_vec[DEF_LOF] = lof;
    event_vec[DEF_LOS]  = los_ev;
    event_vec[DEF_SEF]  = sef_ev;
    event_vec[DEF_LOF]  = lof_ev;
  end

  fdm_reg_if #(
    .DATA_W   (DATA_W),
    .THR_W    (THR_W),
    .THR_INIT (THR_INIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .defects   (defect_vec),
    .events    (event_vec),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n),
    .thr_o     (thr),
    .ist_o     (int_stat),
    .ien_o     (int_en)
  );

endmodule

// File: rtl/fdm_checker.sv
module fdm_checker
  import fdm_pkg::*;
(
  input logic               clk,
  input logic               rst_i,
  input logic               frm_tick,
  input logic               frm_ok,
  input logic               los_in,
  input logic               reg_rd,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [NUM_DEF-1:0] defects,
  input logic [NUM_DEF-1:0] ist,
  input logic [NUM_DEF-1:0] ien,
  input logic               irq_n
);

  // R3: SEF rises only on a frame strobe whose alignment failed
  a_r3_sef_on_bad_frame: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(defects[DEF_SEF]) |-> $past(frm_tick && !frm_ok));

  // R5: LOF is declared only while SEF is already declared
  a_r5_lof_after_sef: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(defects[DEF_LOF]) |-> ($past(defects[DEF_SEF]) && defects[DEF_SEF]));

  // R6: LOF clears only on a good frame with SEF clear
  a_r6_lof_clear_good: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(defects[DEF_LOF]) |-> $past(frm_tick && frm_ok && !defects[DEF_SEF]));

  // R8: LOS trails the input by one clock
  a_r8_los_follow: assert property (@(posedge clk) disable iff (!rst_i)
    $past(rst_i) |-> (defects[DEF_LOS] == $past(los_in)));

  // R9: an enabled change of SEF latches its pending bit
  a_r9_sef_latch: assert property (@(posedge clk) disable iff (!rst_i)
    (($rose(defects[DEF_SEF]) || $fell(defects[DEF_SEF])) && $past(ien[DEF_SEF]))
      |-> ist[DEF_SEF]);

  // R10: a read of the pending register with no defect change clears it
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(reg_rd && reg_addr == A_ISR) && $stable(defects)) |-> (ist == '0));

  // R11: a low interrupt line needs an enable and a pending bit
  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_i)
    !irq_n |-> ((ien != '0) && (ist != '0)));

endmodule

bind sonet_frame_defect_mon fdm_checker u_chk (
  .clk      (clk),
  .rst_i    (rst_sync_n),
  .frm_tick (frm_tick),
  .frm_ok   (frm_ok),
  .los_in   (los_in),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .defects  (defect_vec),
  .ist      (int_stat),
  .ien      (int_en),
  .irq_n    (irq_n)
);

// File: tb/test_sonet_frame_defect_mon.sv
module test_sonet_frame_defect_mon;

  localparam int SB = 4;
  localparam int SG = 2;
  localparam int LP = 8;
  localparam int TI = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n, frm_tick, frm_ok, los_in, reg_wr, reg_rd;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          irq_n;

  always #10 clk = ~clk;

  sonet_frame_defect_mon #(
    .SEF_BAD_FRAMES (SB), .SEF_GOOD_FRAMES (SG), .LOF_PERSIST_FRAMES (LP),
    .THR_W (4), .THR_INIT (4'(TI)), .DATA_W (DW), .RST_STAGES (2)
  ) i_sonet_frame_defect_mon (
    .clk (clk), .rst_n (rst_n), .frm_tick (frm_tick), .frm_ok (frm_ok),
    .los_in (los_in), .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_n (irq_n)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit checking = 0, done = 0;

  // behavioural model
  int m_los, m_sef, m_lof, m_good, m_bad, m_per, m_hold, m_ist, m_ien, m_thr;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_rdata(logic [1:0] a);
    case (a)
      2'd0:    return m_los | (m_sef << 1) | (m_lof << 2);
      2'd1:    return m_ist;
      2'd2:    return m_ien;
      default: return m_thr;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] a);
    case (a)
      2'd0:    return "R2";
      2'd1:    return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic m_reset();
    m_los = 1; m_sef = 1; m_lof = 1; m_good = 0; m_bad = 0; m_per = 0;
    m_ist = 0; m_ien = 0; m_thr = TI; m_hold = 0;
  endtask

  task automatic m_step();
    int old_def, new_def, need, chg;
    old_def = m_los | (m_sef << 1) | (m_lof << 2);
    if (frm_tick) begin
      if (frm_ok) begin m_good++; m_bad = 0; end
      else begin m_bad++; m_good = 0; end
      if (m_sef == 1 && m_lof == 0) m_per++; else m_per = 0;
      need = (m_thr == 0) ? 1 : m_thr;
      chg = 0;
      if (m_sef == 0 && m_lof == 0) begin
        if (!frm_ok && m_bad >= SB) begin m_sef = 1; chg = 1; end
      end else if (m_sef == 1 && m_lof == 0) begin
        if (frm_ok && m_good >= SG) begin m_sef = 0; chg = 1; end
        else if (m_per >= LP) begin m_lof = 1; chg = 1; end
      end else if (m_sef == 1) begin
        if (frm_ok && m_good >= SG) begin m_sef = 0; chg = 1; end
      end else begin
        if (frm_ok && m_good >= need) begin m_lof = 0; chg = 1; end
        else if (!frm_ok && m_bad >= SB) begin m_sef = 1; chg = 1; end
      end
      if (chg != 0) begin m_good = 0; m_bad = 0; m_per = 0; end
    end
    m_los = los_in ? 1 : 0;
    new_def = m_los | (m_sef << 1) | (m_lof << 2);
    if (reg_rd && reg_addr == 2'd1) m_ist = 0;
    m_ist = m_ist | ((old_def ^ new_def) & m_ien);
    if (reg_wr && reg_addr == 2'd2) m_ien = int'(reg_wdata) & 7;
    if (reg_wr && reg_addr == 2'd3) m_thr = int'(reg_wdata) & 15;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else if (m_hold < 2) m_hold++;
    else m_step();
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (checking && !done) begin
      chk(tag_of(reg_addr), 32'(reg_rdata), 32'(m_rdata(reg_addr)));
      chk("R11", 32'(irq_n), ((m_ist & m_ien) != 0) ? 32'd0 : 32'd1);
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic idle();
    @(posedge clk); #2;
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(posedge clk); #2; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2; reg_wr = 0;
  endtask

  task automatic rd_isr();
    @(posedge clk); #2; reg_rd = 1; reg_addr = 2'd1;
    @(posedge clk); #2; reg_rd = 0;
  endtask

  task automatic peek(logic [1:0] a, int exp, string tag);
    @(posedge clk); #2; reg_addr = a; reg_rd = 0; reg_wr = 0;
    @(negedge clk); chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic chk_irq(logic exp, string tag);
    @(negedge clk); chk(tag, 32'(irq_n), 32'(exp));
  endtask

  // one frame strobe, then idle cycles carrying the opposite frm_ok
  task automatic frame(logic ok);
    @(posedge clk); #2; frm_tick = 1; frm_ok = ok;
    @(posedge clk); #2; frm_tick = 0; frm_ok = ~ok;
    @(posedge clk); #2;
  endtask

  task automatic frames(logic ok, int n);
    for (int k = 0; k < n; k++) frame(ok);
  endtask

  initial begin
    m_reset();
    rst_n = 0; frm_tick = 0; frm_ok = 0; los_in = 1;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    checking = 1;
    repeat (3) idle();

    // R1 reset values
    peek(2'd0, 7, "R1");
    peek(2'd1, 0, "R1");
    peek(2'd2, 0, "R1");
    peek(2'd3, TI, "R1");
    chk_irq(1'b1, "R1");

    // R2 status is read only; R8/R9/R11 on an LOS change
    wr(2'd2, 8'h07);
    wr(2'd0, 8'h00);
    peek(2'd0, 7, "R2");
    @(posedge clk); #2; los_in = 0;
    peek(2'd0, 6, "R8");
    peek(2'd1, 1, "R9");
    chk_irq(1'b0, "R11");

    // R10 read clears
    rd_isr();
    peek(2'd1, 0, "R10");
    chk_irq(1'b1, "R11");

    // R4, R6 from the reset state with threshold 3
    wr(2'd3, 8'h03);
    frames(1'b1, 2);
    peek(2'd0, 4, "R4");
    frames(1'b1, 2);
    frame(1'b0);
    peek(2'd0, 4, "R6");
    frames(1'b1, 2);
    peek(2'd0, 4, "R6");
    frame(1'b1);
    peek(2'd0, 0, "R6");

    // R3 bad-frame run and restart
    frames(1'b0, 3);
    frame(1'b1);
    frames(1'b0, 3);
    peek(2'd0, 0, "R3");
    frame(1'b0);
    peek(2'd0, 2, "R3");

    // R5 persistence to LOF
    frames(1'b0, LP - 1);
    peek(2'd0, 2, "R5");
    frame(1'b0);
    peek(2'd0, 6, "R5");

    // R4 then R7
    frames(1'b1, 2);
    peek(2'd0, 4, "R4");
    frames(1'b0, SB - 1);
    peek(2'd0, 4, "R7");
    frame(1'b0);
    peek(2'd0, 6, "R7");

    // R6 threshold 0 counts as one frame
    frames(1'b1, 2);
    peek(2'd0, 4, "R6");
    wr(2'd3, 8'h00);
    peek(2'd3, 0, "R12");
    frame(1'b1);
    peek(2'd0, 0, "R6");

    // R9 disabled bits do not latch
    wr(2'd2, 8'h00);
    rd_isr();
    @(posedge clk); #2; los_in = 1;
    peek(2'd0, 1, "R8");
    peek(2'd1, 0, "R9");
    chk_irq(1'b1, "R9");

    // R10 same-cycle event wins over read
    wr(2'd2, 8'h07);
    rd_isr();
    @(posedge clk); #2; los_in = 0; reg_rd = 1; reg_addr = 2'd1;
    @(posedge clk); #2; reg_rd = 0;
    peek(2'd1, 1, "R10");
    chk_irq(1'b0, "R11");

    // R12 masking and R2 ignored writes
    wr(2'd2, 8'hFF);
    peek(2'd2, 7, "R12");
    wr(2'd3, 8'hF5);
    peek(2'd3, 5, "R12");
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);
    peek(2'd0, 0, "R2");
    peek(2'd1, 1, "R2");

    repeat (4) idle();
    done = 1;
    summary();
    $finish;
  end

endmodule